// File: doc/BRIEF.md
# Byte/Word Selectable Read-Only Memory Front End

This block sits between a 512K x 16 read-only array and a parallel bus. It can present the array in two ways. In wide mode it returns one 16-bit word per address. In narrow mode it returns one byte of that word, and an extra low-order address bit chooses which byte. In narrow mode the top data line changes role and becomes that extra address input. The array itself is external: the block puts the address on `mem_addr_o` and reads the stored word back on `mem_data_i` in the same cycle.

Two active-low strobes gate the bus. Chip enable selects the device, and while it is high the block is in standby. Output enable gates the data onto the lines. A side-band identifier flag, which stands for an overvoltage on address bit 9, switches the block to return fixed identifier codes instead of array data. Each data line has its own drive-enable output in place of a real tri-state, and an undriven line always reads zero.

Access delay is counted in clock cycles. The address path and the output-enable path each have their own latency, and data comes out when the slower of the two has finished. Any change on the address, on the byte-select bit, on the mode pin or on the identifier flag starts the address latency again from the beginning.

Top module: `rom_bw_front`

## Requirements
- R1: With `wide_sel_i`=1 and the identifier flag low, a completed access drives all 16 lines (`dq_oe_o`=16'hFFFF) with the addressed word; in this mode the drive mask is only ever all-zero or all-one.
- R2: With `wide_sel_i`=0, `byte_sel_i`=0 places bits 7:0 of the addressed word on `dq_o[7:0]`, and `byte_sel_i`=1 places bits 15:8 there.
- R3: With `wide_sel_i`=0, lines 15:8 are never driven; a completed access gives `dq_oe_o`=16'h00FF.
- R4: While `ce_n_i` is high, no line is driven in the following cycle, whatever `oe_n_i` is.
- R5: While `ce_n_i` is low and `oe_n_i` is high, no line is driven in the following cycle.
- R6: With `ident_i`=1 and address bits 18:1 all zero, `addr_i[0]`=0 returns 8'h20 and `addr_i[0]`=1 returns 8'hB2 on `dq_o[7:0]`, with `dq_oe_o`=16'h00FF in both modes.
- R7: With `ident_i`=1 and any of address bits 18:1 set, the data returned is 8'h00 on lines 7:0 and `ident_err_o` goes high one cycle later; `ident_err_o` is low whenever the flag was low in the previous cycle.
- R8: Data is driven after the ACC_LAT-th rising edge at which chip enable is low and the address key is unchanged; a change of address restarts this count, so nothing is driven in the cycle after an address change.
- R9: Data is driven no earlier than after the OE_LAT-th rising edge at which output enable is low, so the later of the two latencies sets when data appears.
- R10: A change of `wide_sel_i` from 0 to 1 at an unchanged address keeps every line undriven for the full ACC_LAT count before the word appears.
- R11: A data line whose drive enable is low reads 0.
- R12: While reset is asserted, `dq_o`, `dq_oe_o` and `ident_err_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 19 | Word address |
| wide_sel_i | input | 1 | 1: word mode, 0: byte mode |
| byte_sel_i | input | 1 | Shared pin sampled as the byte-select address bit in byte mode; ignored in word mode |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| ident_i | input | 1 | Identifier mode flag (high voltage on address bit 9) |
| mem_addr_o | output | 19 | Address to the array |
| mem_data_i | input | 16 | Word read from the array |
| dq_o | output | 16 | Data lines; bit 15 is the shared pin in word mode |
| dq_oe_o | output | 16 | Per-line drive enable |
| ident_err_o | output | 1 | Identifier access made with a nonzero upper address |

## Verification
A table of accesses alternates between word reads, lower and upper byte reads, and identifier reads at addresses whose upper and lower bytes differ. Each entry changes at least one field of the key, so every one of them also tests the restart of the latency count. Swapping the two halves of the word, driving the upper lines in byte mode, or mixing up the two identifier codes each gives a wrong value in at least one entry. Directed sequences count the edges one short of each latency, move the address partway through a count, raise output enable on a settled address, switch from byte to word mode at the same address, and reset with the error flag set. These separate a correct count from one that is off by one, a count that is not restarted, and a mode switch that is not restarted.

// File: rtl/rom_bw_pkg.sv
package rom_bw_pkg;

  localparam int WORD_W = 16;
  localparam int BYTE_W = WORD_W / 2;

  localparam logic [BYTE_W-1:0] MAKER_ID  = 8'h20;
  localparam logic [BYTE_W-1:0] DEVICE_ID = 8'hB2;

  localparam logic [WORD_W-1:0] MASK_LOW  = {{BYTE_W{1'b0}}, {BYTE_W{1'b1}}};
  localparam logic [WORD_W-1:0] MASK_FULL = {WORD_W{1'b1}};

  typedef enum logic [1:0] {
    VIEW_WORD  = 2'd0,
    VIEW_BYTE  = 2'd1,
    VIEW_IDENT = 2'd2
  } view_e;

endpackage

// File: rtl/rom_bw_timer.sv
module rom_bw_timer #(
  parameter int LAT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic restart_i,
  output logic done_next_o
);

  localparam int CW = (LAT < 1) ? 1 : $clog2(LAT + 1);
  localparam logic [CW-1:0] TOP = CW'(LAT);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    if (clr_i)
      cnt_d = '0;
    else if (restart_i)
      cnt_d = CW'(1);
    else if (cnt_q == TOP)
      cnt_d = cnt_q;
    else
      cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  assign done_next_o = (cnt_d == TOP);

endmodule

// File: rtl/rom_bw_fmt.sv
module rom_bw_fmt
  import rom_bw_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic              wide_i,
  input  logic              byte_hi_i,
  input  logic              ident_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [WORD_W-1:0] data_o,
  output logic [WORD_W-1:0] drive_o,
  output logic              ident_bad_o
);

  view_e             view;
  logic [BYTE_W-1:0] pick;
  logic              upper_set;

  assign upper_set = |addr_i[ADDR_W-1:1];

  always_comb begin
    if (ident_i)
      view = VIEW_IDENT;
    else if (wide_i)
      view = VIEW_WORD;
    else
      view = VIEW_BYTE;
  end

  always_comb begin
    pick = byte_hi_i ? word_i[WORD_W-1:BYTE_W] : word_i[BYTE_W-1:0];
  end

  always_comb begin
    data_o  = '0;
    drive_o = '0;
    unique case (view)
      VIEW_WORD: begin
        data_o  = word_i;
        drive_o = MASK_FULL;
      end
      VIEW_BYTE: begin
        data_o  = {{BYTE_W{1'b0}}, pick};
        drive_o = MASK_LOW;
      end
      VIEW_IDENT: begin
        if (upper_set)
          data_o = '0;
        else
          data_o = {{BYTE_W{1'b0}}, (addr_i[0] ? DEVICE_ID : MAKER_ID)};
        drive_o = MASK_LOW;
      end
      default: begin
        data_o  = '0;
        drive_o = '0;
      end
    endcase
  end

  assign ident_bad_o = ident_i & upper_set;

endmodule

// File: rtl/rom_bw_front.sv
module rom_bw_front
  import rom_bw_pkg::*;
#(
  parameter int ADDR_W  = 19,
  parameter int ACC_LAT = 5,
  parameter int OE_LAT  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wide_sel_i,
  input  logic              byte_sel_i,
  input  logic              ce_n_i,
  input  logic              oe_n_i,
  input  logic              ident_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [WORD_W-1:0] mem_data_i,
  output logic [WORD_W-1:0] dq_o,
  output logic [WORD_W-1:0] dq_oe_o,
  output logic              ident_err_o
);

  localparam int KEY_W = ADDR_W + 3;

  // reset: asynchronous assert, synchronous release
  logic rst_meta_n;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  // access key: anything whose change restarts the address latency
  logic [KEY_W-1:0] key_now;
  logic [KEY_W-1:0] key_q;
  logic             key_moved;

  assign key_now   = {ident_i, wide_sel_i, (~wide_sel_i & byte_sel_i), addr_i};
  assign key_moved = (key_now != key_q);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)
      key_q <= '0;
    else
      key_q <= key_now;
  end

  // latency counters
  logic acc_done;
  logic oe_done;

  rom_bw_timer #(.LAT(ACC_LAT)) u_acc_timer (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .clr_i      (ce_n_i),
    .restart_i  (key_moved),
    .done_next_o(acc_done)
  );

  rom_bw_timer #(.LAT(OE_LAT)) u_oe_timer (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .clr_i      (oe_n_i),
    .restart_i  (1'b0),
    .done_next_o(oe_done)
  );

  // formatting of the word read from the array
  assign mem_addr_o = addr_i;

  logic [WORD_W-1:0] fmt_data;
  logic [WORD_W-1:0] fmt_drive;
  logic              fmt_bad;

  rom_bw_fmt #(.ADDR_W(ADDR_W)) u_fmt (
    .word_i     (mem_data_i),
    .wide_i     (wide_sel_i),
    .byte_hi_i  (byte_sel_i),
    .ident_i    (ident_i),
    .addr_i     (addr_i),
    .data_o     (fmt_data),
    .drive_o    (fmt_drive),
    .ident_bad_o(fmt_bad)
  );

  // output stage: next state, then registers
  logic              valid_d;
  logic [WORD_W-1:0] dq_d;
  logic [WORD_W-1:0] oe_d;
  logic              out_en;

  assign valid_d = ~ce_n_i & ~oe_n_i & acc_done & oe_done;
  assign out_en  = 1'b1;

  always_comb begin
    if (valid_d) begin
      dq_d = fmt_data & fmt_drive;
      oe_d = fmt_drive;
    end else begin
      dq_d = '0;
      oe_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      dq_o        <= '0;
      dq_oe_o     <= '0;
      ident_err_o <= 1'b0;
    end else if (out_en) begin
      dq_o        <= dq_d;
      dq_oe_o     <= oe_d;
      ident_err_o <= fmt_bad;
    end
  end

endmodule

// File: rtl/rom_bw_front_chk.sv
module rom_bw_front_chk #(
  parameter int ADDR_W  = 19,
  parameter int ACC_LAT = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wide_sel_i,
  input logic              ce_n_i,
  input logic              oe_n_i,
  input logic              ident_i,
  input logic [15:0]       dq_o,
  input logic [15:0]       dq_oe_o,
  input logic              ident_err_o
);

  a_r4_standby_undriven: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n_i |=> (dq_oe_o == 16'h0000));

  a_r5_disable_undriven: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n_i && oe_n_i) |=> (dq_oe_o == 16'h0000));

  a_r3_byte_upper_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_sel_i |=> (dq_oe_o[15:8] == 8'h00));

  a_r6_ident_upper_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ident_i |=> (dq_oe_o[15:8] == 8'h00));

  a_r7_ident_err_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (ident_i && (addr_i[ADDR_W-1:1] != '0)) |=> ident_err_o);

  a_r7_ident_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ident_i |=> !ident_err_o);

  a_r1_word_mask_whole: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_sel_i && !ident_i) |=> ((dq_oe_o == 16'h0000) || (dq_oe_o == 16'hFFFF)));

  a_r8_addr_move_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    ((ACC_LAT > 1) && !$stable(addr_i)) |=> (dq_oe_o == 16'h0000));

  a_r11_undriven_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((dq_o & ~dq_oe_o) == 16'h0000));

endmodule

bind rom_bw_front rom_bw_front_chk #(
  .ADDR_W (ADDR_W),
  .ACC_LAT(ACC_LAT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .addr_i     (addr_i),
  .wide_sel_i (wide_sel_i),
  .ce_n_i     (ce_n_i),
  .oe_n_i     (oe_n_i),
  .ident_i    (ident_i),
  .dq_o       (dq_o),
  .dq_oe_o    (dq_oe_o),
  .ident_err_o(ident_err_o)
);

// File: tb/rom_bw_front_test.sv
module rom_bw_front_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW  = 19;
  localparam int ACC = 5;
  localparam int OEL = 3;
  localparam int NV  = 9;

  typedef struct packed {
    logic          wide;
    logic          bsel;
    logic          ident;
    logic [AW-1:0] addr;
    logic [15:0]   dq;
    logic [15:0]   oe;
    logic          err;
  } vec_t;

  // array word at address a: {a[7:0]^8'hC3, a[7:0]} (indexed by a[5:0])
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 1'b0, 19'h00005, 16'hC605, 16'hFFFF, 1'b0},  // R1 word
    '{1'b0, 1'b0, 1'b0, 19'h00012, 16'h0012, 16'h00FF, 1'b0},  // R2 lower byte
    '{1'b0, 1'b1, 1'b0, 19'h00012, 16'h00D1, 16'h00FF, 1'b0},  // R2 upper byte
    '{1'b1, 1'b1, 1'b0, 19'h0003F, 16'hFC3F, 16'hFFFF, 1'b0},  // R1 word
    '{1'b0, 1'b1, 1'b0, 19'h40021, 16'h00E2, 16'h00FF, 1'b0},  // R3 upper byte
    '{1'b1, 1'b0, 1'b1, 19'h00000, 16'h0020, 16'h00FF, 1'b0},  // R6 maker code
    '{1'b0, 1'b0, 1'b1, 19'h00001, 16'h00B2, 16'h00FF, 1'b0},  // R6 device code
    '{1'b1, 1'b0, 1'b1, 19'h00200, 16'h0000, 16'h00FF, 1'b1},  // R7 bad ident
    '{1'b0, 1'b0, 1'b0, 19'h0003F, 16'h003F, 16'h00FF, 1'b0}   // R3 lower byte
  };

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          wide;
  logic          bsel;
  logic          ce_n;
  logic          oe_n;
  logic          ident;
  logic [AW-1:0] mem_addr;
  logic [15:0]   mem_data;
  logic [15:0]   dq;
  logic [15:0]   dq_oe;
  logic          err;

  logic [15:0] mem [64];

  int checks;
  int errors;
  bit done;

  rom_bw_front #(.ADDR_W(AW), .ACC_LAT(ACC), .OE_LAT(OEL)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_i     (addr),
    .wide_sel_i (wide),
    .byte_sel_i (bsel),
    .ce_n_i     (ce_n),
    .oe_n_i     (oe_n),
    .ident_i    (ident),
    .mem_addr_o (mem_addr),
    .mem_data_i (mem_data),
    .dq_o       (dq),
    .dq_oe_o    (dq_oe),
    .ident_err_o(err)
  );

  assign mem_data = mem[mem_addr[5:0]];

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    checks = 0;
    errors = 0;
    done   = 1'b0;
    for (int i = 0; i < 64; i++)
      mem[i] = {8'(i) ^ 8'hC3, 8'(i)};
    rst_n = 1'b0;
    addr  = '0;
    wide  = 1'b1;
    bsel  = 1'b0;
    ce_n  = 1'b1;
    oe_n  = 1'b1;
    ident = 1'b0;
    edges(3);
    check("R12 reset dq", 32'(dq), 32'h0);
    check("R12 reset oe", 32'(dq_oe), 32'h0);
    check("R12 reset err", 32'(err), 32'h0);
    rst_n = 1'b1;
    edges(4);

    // table walk: every entry changes the key, so each one waits out ACC
    ce_n = 1'b0;
    oe_n = 1'b0;
    for (int v = 0; v < NV; v++) begin
      wide  = VEC[v].wide;
      bsel  = VEC[v].bsel;
      ident = VEC[v].ident;
      addr  = VEC[v].addr;
      edges(ACC);
      check($sformatf("vector %0d data (R1 R2 R3 R6 R7)", v), 32'(dq), 32'(VEC[v].dq));
      check($sformatf("vector %0d mask (R1 R3 R6)", v), 32'(dq_oe), 32'(VEC[v].oe));
      check($sformatf("vector %0d err (R7)", v), 32'(err), 32'(VEC[v].err));
    end

    // R8: one edge short, then an address move restarts the count
    ident = 1'b0;
    wide  = 1'b1;
    addr  = 19'h00005;
    edges(ACC - 1);
    check("R8 one edge short", 32'(dq_oe), 32'h0);
    addr = 19'h00012;
    edges(ACC - 1);
    check("R8 restarted count short", 32'(dq_oe), 32'h0);
    check("R11 undriven reads zero", 32'(dq), 32'h0);
    edges(1);
    check("R8 restarted count done data", 32'(dq), 32'hD112);
    check("R8 restarted count done mask", 32'(dq_oe), 32'hFFFF);

    // R5 then R9: output enable on a settled address
    oe_n = 1'b1;
    edges(ACC + 1);
    check("R5 output disable", 32'(dq_oe), 32'h0);
    oe_n = 1'b0;
    edges(OEL - 1);
    check("R9 oe one edge short", 32'(dq_oe), 32'h0);
    edges(1);
    check("R9 oe count done", 32'(dq), 32'hD112);

    // R4: standby whatever output enable does
    ce_n = 1'b1;
    edges(3);
    check("R4 standby mask", 32'(dq_oe), 32'h0);
    check("R11 standby data", 32'(dq), 32'h0);

    // R10: byte to word at the same address
    ce_n = 1'b0;
    wide = 1'b0;
    bsel = 1'b1;
    addr = 19'h0003F;
    edges(ACC + 1);
    check("R2 upper byte settled", 32'(dq), 32'h00FC);
    wide = 1'b1;
    edges(ACC - 1);
    check("R10 mode switch short", 32'(dq_oe), 32'h0);
    edges(1);
    check("R10 mode switch data", 32'(dq), 32'hFC3F);
    check("R10 mode switch mask", 32'(dq_oe), 32'hFFFF);

    // R7 flag, then R12 reset clears it
    ident = 1'b1;
    addr  = 19'h00400;
    edges(2);
    check("R7 err raised", 32'(err), 32'h1);
    rst_n = 1'b0;
    #1;
    check("R12 reset clears err", 32'(err), 32'h0);
    check("R12 reset clears mask", 32'(dq_oe), 32'h0);
    edges(1);
    rst_n = 1'b1;
    edges(2);

    done = 1'b1;
    finish_run();
  end

endmodule